// File: doc/BRIEF.md
# Adaptive Output Port Selector

This block sits after the routing lookup in a memory-network router. Each request carries a ranked list of candidate output ports, all of which bring the packet closer to its destination, together with the source and destination coordinates. The selector returns one output port and one of two virtual channels. The result is held in a registered output slot that uses a valid/ready handshake.

To spread load, the selector keeps one saturating occupancy counter per output port. A counter goes up when the selector routes a packet to that port and goes down when the port reports a dequeue. A candidate counts as busy when its counter is at or above a programmable threshold. The first candidate in rank order that is not busy wins. If every candidate is busy, the top-ranked candidate is used.

The virtual channel depends only on the direction of travel in coordinate space. This keeps the upward-moving and downward-moving traffic apart. A reconfiguration pulse clears every counter.

Top module: `adaptive_port_selector`

## Requirements
- R1: After reset, out_valid is 0, req_ready is 1 and every port counter is 0.
- R2: A request is accepted when req_valid and req_ready are both 1, where req_ready = !out_valid || out_ready. The decision appears on out_valid/out_port/out_vc one cycle later. While out_valid is 1 and out_ready is 0, the outputs hold steady and no new request is accepted.
- R3: out_vc is 1 when the destination coordinate is below the source coordinate. Otherwise (destination above or equal to source) it is 0.
- R4: Each accepted request adds one to the counter of the port it is sent to. The counter saturates at QUEUE_DEPTH-1 (log2(QUEUE_DEPTH) bits).
- R5: A 1 on bit p of port_deq subtracts one from port p's counter. The counter saturates at 0.
- R6: When an increment and a decrement reach the same port in the same cycle, that counter keeps its value.
- R7: Candidate k sits in req_cands[k*PORT_W +: PORT_W], and rank 0 is the most preferred. A candidate is busy when its counter is at or above busy_thresh. The chosen port is the lowest-ranked (most preferred) candidate that is not busy.
- R8: When every candidate is busy, including whenever busy_thresh is 0, the rank-0 candidate is chosen.
- R9: A 1 on reconfig_clr clears all counters at the next edge. The clear wins over any increment or decrement in that cycle, but a request in that cycle is still accepted and issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reconfig_clr | input | 1 | Clear all occupancy counters |
| busy_thresh | input | log2(QUEUE_DEPTH) | Count at or above which a port is busy |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_cands | input | NUM_CAND*PORT_W | Ranked candidate ports, rank 0 in the low bits |
| req_src | input | COORD_W | Source coordinate |
| req_dst | input | COORD_W | Destination coordinate |
| port_deq | input | NUM_PORTS | Per-port dequeue pulses |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes the decision |
| out_port | output | PORT_W | Chosen output port |
| out_vc | output | 1 | Chosen virtual channel |

## Verification
The counters are not visible at the ports, so a wrong count shows up only as a different out_port. This happens one cycle after the next accepted request whose candidates include that port, and only when the wrong count falls on the other side of busy_thresh. For this reason the bench sweeps low thresholds and pins the threshold at the saturation limit and at zero. Under those settings, wrap-around, lost cancellations or a missed clear turn into a port mismatch within a few requests. Virtual-channel and handshake faults are visible on the very first decision that follows.

// File: rtl/aps_pkg.sv
package aps_pkg;
  // Virtual channel by direction of travel in coordinate space
  typedef enum logic {
    VC_ASCEND  = 1'b0,
    VC_DESCEND = 1'b1
  } vc_e;
endpackage

// File: rtl/aps_occ_counter.sv
module aps_occ_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && !dec && count != CNT_MAX) begin
      count <= count + 1'b1;
    end else if (dec && !inc && count != '0) begin
      count <= count - 1'b1;
    end
  end

  // R4: single increment steps by one below the ceiling
  p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && !clr && count != CNT_MAX) |=> count == $past(count) + 1'b1);
  // R4: ceiling holds
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && !clr && count == CNT_MAX) |=> count == CNT_MAX);
  // R5: floor holds
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && !clr && count == '0) |=> count == '0);
  // R6: simultaneous inc/dec cancel
  p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    (inc && dec && !clr) |=> $stable(count));
  // R9: clear empties the counter
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
endmodule

// File: rtl/aps_cand_picker.sv
module aps_cand_picker #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CAND  = 3,
  parameter int CNT_W     = 4,
  parameter int PORT_W    = 3
) (
  input  logic [NUM_PORTS*CNT_W-1:0] counts,
  input  logic [NUM_CAND*PORT_W-1:0] cands,
  input  logic [CNT_W-1:0]           thresh,
  output logic [PORT_W-1:0]          pick_port
);
  localparam int RANK_W = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1;

  logic [CNT_W-1:0]  cnt_arr  [NUM_PORTS];
  logic [PORT_W-1:0] cand_arr [NUM_CAND];
  logic [NUM_CAND-1:0] busy;
  logic [RANK_W-1:0] pick_idx;
  logic              found;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack_cnt
    assign cnt_arr[p] = counts[p*CNT_W +: CNT_W];
  end

  for (genvar k = 0; k < NUM_CAND; k++) begin : g_cand
    assign cand_arr[k] = cands[k*PORT_W +: PORT_W];
    assign busy[k]     = cnt_arr[cand_arr[k]] >= thresh;
  end

  // Highest-ranked idle candidate, rank 0 when all are busy
  always_comb begin
    pick_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_CAND; i++) begin
      if (!found && !busy[i]) begin
        found    = 1'b1;
        pick_idx = i[RANK_W-1:0];
      end
    end
  end

  assign pick_port = cand_arr[pick_idx];
endmodule

// File: rtl/adaptive_port_selector.sv
module adaptive_port_selector #(
  parameter int NUM_PORTS   = 8,
  parameter int QUEUE_DEPTH = 16,
  parameter int NUM_CAND    = 3,
  parameter int COORD_W     = 7,
  localparam int CNT_W      = $clog2(QUEUE_DEPTH),
  localparam int PORT_W     = $clog2(NUM_PORTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reconfig_clr,
  input  logic [CNT_W-1:0]           busy_thresh,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [NUM_CAND*PORT_W-1:0] req_cands,
  input  logic [COORD_W-1:0]         req_src,
  input  logic [COORD_W-1:0]         req_dst,
  input  logic [NUM_PORTS-1:0]       port_deq,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [PORT_W-1:0]          out_port,
  output logic                       out_vc
);
  import aps_pkg::*;

  logic                       accept;
  logic [PORT_W-1:0]          pick_port;
  logic [NUM_PORTS*CNT_W-1:0] counts;
  vc_e                        vc_next;

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;
  assign vc_next   = (req_dst < req_src) ? VC_DESCEND : VC_ASCEND;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic inc_p;
    assign inc_p = accept && (pick_port == PORT_W'(p));
    aps_occ_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (reconfig_clr),
      .inc   (inc_p),
      .dec   (port_deq[p]),
      .count (counts[p*CNT_W +: CNT_W])
    );
  end

  aps_cand_picker #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_CAND  (NUM_CAND),
    .CNT_W     (CNT_W),
    .PORT_W    (PORT_W)
  ) i_pick (
    .counts    (counts),
    .cands     (req_cands),
    .thresh    (busy_thresh),
    .pick_port (pick_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_vc    <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_port  <= pick_port;
      out_vc    <= vc_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: accepted request is issued next cycle
  p_issue_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  // R2: stalled decision stays put
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_vc)));
  // R3: upward travel uses channel 0
  p_vc_up_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && req_dst > req_src) |=> out_vc == 1'b0);
  // R3: downward travel uses channel 1
  p_vc_down_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && req_dst < req_src) |=> out_vc == 1'b1);
  // R8: zero threshold makes all busy, rank 0 wins
  p_rank0_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && busy_thresh == '0) |=> out_port == $past(req_cands[PORT_W-1:0]));
endmodule

// File: tb/test_adaptive_port_selector.sv
`timescale 1ns/1ps
module test_adaptive_port_selector;
  localparam int NP = 8, QD = 16, NC = 3, CW = 7;
  localparam int CNTW = 4, PW = 3, CMAX = QD - 1;

  logic clk = 1'b0, rst = 1'b1, reconfig_clr = 1'b0;
  logic [CNTW-1:0] busy_thresh = '0;
  logic req_valid = 1'b0, req_ready;
  logic [NC*PW-1:0] req_cands = '0;
  logic [CW-1:0] req_src = '0, req_dst = '0;
  logic [NP-1:0] port_deq = '0;
  logic out_valid, out_ready = 1'b1, out_vc;
  logic [PW-1:0] out_port;

  int cnt [NP];
  bit mo_valid;
  int mo_port, mo_vc;
  int thr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adaptive_port_selector #(.NUM_PORTS(NP), .QUEUE_DEPTH(QD), .NUM_CAND(NC), .COORD_W(CW))
    i_adaptive_port_selector (
      .clk(clk), .rst(rst), .reconfig_clr(reconfig_clr), .busy_thresh(busy_thresh),
      .req_valid(req_valid), .req_ready(req_ready), .req_cands(req_cands),
      .req_src(req_src), .req_dst(req_dst), .port_deq(port_deq),
      .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port), .out_vc(out_vc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NC*PW-1:0] pk(input int a, input int b, input int c);
    logic [PW-1:0] x = PW'(a), y = PW'(b), z = PW'(c);
    return {z, y, x};
  endfunction

  // R7/R8: first candidate below threshold, else rank 0
  function automatic int exp_pick(input logic [NC*PW-1:0] c, input int th);
    for (int i = 0; i < NC; i++) begin
      int p = int'(c[i*PW +: PW]);
      if (cnt[p] < th) return p;
    end
    return int'(c[PW-1:0]);
  endfunction

  // R3: direction decides channel
  function automatic int exp_vc(input int s, input int d);
    return (d < s) ? 1 : 0;
  endfunction

  // One cycle: drive at negedge, check after the following negedge
  task automatic step(input bit v, input logic [NC*PW-1:0] c, input int s, input int d,
                      input logic [NP-1:0] dq, input bit clr, input bit ordy, input string tag);
    bit er, acc;
    int ep, ev;
    req_valid = v; req_cands = c; req_src = CW'(s); req_dst = CW'(d);
    port_deq = dq; reconfig_clr = clr; out_ready = ordy; busy_thresh = CNTW'(thr);
    #1;
    er = !mo_valid || ordy;
    chk(req_ready == er, {tag, " R2 req_ready"}, int'(req_ready), int'(er));
    acc = v && er;
    ep = exp_pick(c, thr);
    ev = exp_vc(s, d);
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      bit ip = acc && (ep == p);
      if (clr) cnt[p] = 0;
      else if (ip && !dq[p]) cnt[p] = (cnt[p] < CMAX) ? cnt[p] + 1 : CMAX;
      else if (dq[p] && !ip) cnt[p] = (cnt[p] > 0) ? cnt[p] - 1 : 0;
    end
    if (acc) begin mo_valid = 1; mo_port = ep; mo_vc = ev; end
    else if (ordy) mo_valid = 0;
    chk(out_valid == mo_valid, {tag, " R2 out_valid"}, int'(out_valid), int'(mo_valid));
    if (mo_valid) begin
      chk(int'(out_port) == mo_port, {tag, " R7 out_port"}, int'(out_port), mo_port);
      chk(int'(out_vc) == mo_vc, {tag, " R3 out_vc"}, int'(out_vc), mo_vc);
    end
  endtask

  task automatic req(input logic [NC*PW-1:0] c, input string tag);
    step(1'b1, c, 10, 20, '0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int p = 0; p < NP; p++) cnt[p] = 0;
    mo_valid = 0; mo_port = 0; mo_vc = 0; thr = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    @(negedge clk);
    req(pk(2, 5, 6), "R1 zero counts pick rank0");

    // R3: channel by direction
    step(1'b1, pk(4, 4, 4), 10, 20, '0, 1'b0, 1'b1, "R3 up");
    step(1'b1, pk(4, 4, 4), 20, 10, '0, 1'b0, 1'b1, "R3 down");
    step(1'b1, pk(4, 4, 4), 33, 33, '0, 1'b0, 1'b1, "R3 equal");

    // R2: stall and hold
    thr = 15;
    step(1'b1, pk(1, 2, 3), 5, 9, '0, 1'b0, 1'b0, "R2 accept into stall");
    step(1'b1, pk(5, 6, 7), 9, 5, '0, 1'b0, 1'b0, "R2 held not accepted");
    step(1'b0, pk(5, 6, 7), 9, 5, '0, 1'b0, 1'b1, "R2 drain");
    step(1'b0, pk(5, 6, 7), 9, 5, '0, 1'b0, 1'b1, "R2 empty");

    // R8 / R4: zero threshold, saturate port 0
    thr = 0;
    for (int i = 0; i < 20; i++) req(pk(0, 1, 2), "R8 R4 saturate port0");
    thr = 15;
    step(1'b0, pk(0, 0, 0), 1, 2, 8'h01, 1'b0, 1'b1, "R5 deq port0");
    req(pk(0, 1, 1), "R4 below ceiling");
    req(pk(0, 1, 1), "R4 at ceiling busy");

    // R5: floor at zero
    step(1'b0, pk(0, 0, 0), 1, 2, 8'h08, 1'b0, 1'b1, "R5 deq empty");
    step(1'b0, pk(0, 0, 0), 1, 2, 8'h08, 1'b0, 1'b1, "R5 deq empty again");
    thr = 1;
    req(pk(3, 4, 5), "R5 floor kept");

    // R6: inc and dec on same port cancel
    thr = 15;
    req(pk(6, 6, 6), "R6 prep");
    req(pk(6, 6, 6), "R6 prep");
    step(1'b1, pk(6, 7, 7), 1, 2, 8'h40, 1'b0, 1'b1, "R6 cancel");
    thr = 3;
    req(pk(6, 7, 7), "R6 check below");
    req(pk(6, 7, 7), "R6 check busy");

    // R9: clear wins over request increment
    step(1'b1, pk(0, 1, 2), 3, 1, 8'h01, 1'b1, 1'b1, "R9 clear with request");
    thr = 1;
    req(pk(0, 1, 2), "R9 port0 cleared");

    // R7 rank walk and R8 all busy
    req(pk(1, 2, 3), "R7 rank walk");
    req(pk(1, 2, 3), "R7 rank walk");
    req(pk(1, 2, 3), "R7 rank walk");
    req(pk(1, 2, 3), "R8 all busy");

    // Random mix: R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 4000; n++) begin
      logic [NP-1:0] dq;
      int s, d;
      if ($urandom_range(0, 49) == 0) thr = $urandom_range(0, CMAX);
      else if ($urandom_range(0, 19) == 0) thr = $urandom_range(0, 5);
      dq = '0;
      for (int p = 0; p < NP; p++) dq[p] = ($urandom_range(0, 3) == 0);
      s = $urandom_range(0, 127);
      d = ($urandom_range(0, 9) == 0) ? s : $urandom_range(0, 127);
      step($urandom_range(0, 3) != 0,
           pk($urandom_range(0, NP-1), $urandom_range(0, NP-1), $urandom_range(0, NP-1)),
           s, d, dq, $urandom_range(0, 299) == 0, $urandom_range(0, 3) != 0, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule